// File: doc/BRIEF.md
# Software-Managed TLB with Address-Space Matching

This block is a fully associative translation buffer. Software fills it and reads it back through explicit commands, and it never walks page tables itself. Each slot maps a pair of adjacent virtual pages, one even and one odd, onto two physical frames. Every slot has its own page-size mask. A slot tagged global matches under any address-space identifier. The block accepts one command per cycle on `cmd_*`, and every command produces a registered response one cycle later.

The six commands are translate, search, write a slot, clear all, read a slot by index, and read the slot at the replacement pointer. Translate looks up a virtual address and returns the frame, the cache attribute and the dirty bit. It also flags hits on a half-page that is not valid, flags uncacheable address windows, and updates hit and miss counters that are kept apart for loads and stores. Slot writes and reads use a packed 32-bit word format, so the same words can go to software and come back unchanged.

Top module: `tlbx_top`

## Requirements
- R1: A slot matches when the virtual page number (`cmd_va[31:12]`) equals `{pair,0}` in every bit above the select bit. The select bit sits just above the run of low ones in the slot's mask (bit 0 when the mask is 0, bit 2 when the mask is 3). The select bit then picks the even half (0) or the odd half (1).
- R2: A slot matches only if its global bit is set or its stored identifier equals `cmd_asid`.
- R3: A slot whose two valid bits are both clear never matches.
- R4: When several slots match, the response reports the lowest-numbered one.
- R5: Translate and search (op 0 and 1) return the matching slot on `rsp_idx` with `rsp_hit`=1. With no match they return all ones and `rsp_hit`=0.
- R6: A translate that matches a slot whose selected half has its valid bit clear reports `rsp_hit`=1 and `rsp_inval`=1.
- R7: A write (op 2) to `cmd_idx` >= the slot count changes no slot. Any other write replaces every field of that slot.
- R8: Clear-all (op 3) zeroes every slot and returns the replacement pointer to 0.
- R9: Pointer read (op 5) returns the slot at the replacement pointer. When `cmd_adv` is set it moves the pointer on by one, wrapping to 0 after the last slot. Pointer read with `cmd_adv` clear leaves the pointer where it is. Reset clears the pointer.
- R10: Word format for reads (op 4 and 5) and writes. The high word is `pair<<11 | asid`. The mask word is `mask<<11`. Each half word is `pfn<<6 | attr<<3 | dirty<<2 | valid<<1 | global`. On a write, the global bit is the AND of bit 0 of the two half words.
- R11: A translate with `cmd_va & 0xA0000000 == 0xA0000000` raises `rsp_uncached`. Other translates leave it clear.
- R12: Each translate counts one hit or one miss, in the load or store set according to `cmd_store`. A translate that matches counts as a hit even when the selected half is invalid. The outputs for total hits, total misses and total accesses are the sums over both sets.
- R13: `rsp_valid` follows `cmd_valid` by one cycle. After reset, the counters are 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 translate, 1 search, 2 write, 3 clear, 4 read index, 5 read pointer |
| cmd_va | input | 32 | Virtual address for translate and search |
| cmd_asid | input | 8 | Requesting address-space identifier |
| cmd_store | input | 1 | Translate is for a store (selects counter set) |
| cmd_idx | input | 5 | Slot index for write and read |
| cmd_adv | input | 1 | Pointer read also advances the pointer |
| wr_hi | input | 32 | Write data: page pair and identifier |
| wr_mask | input | 32 | Write data: page mask |
| wr_lo0 | input | 32 | Write data: even half |
| wr_lo1 | input | 32 | Write data: odd half |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | A slot matched |
| rsp_inval | output | 1 | Matched half is not valid |
| rsp_uncached | output | 1 | Address lies in an uncacheable window |
| rsp_idx | output | 5 | Matching slot or all ones |
| rsp_pfn | output | 20 | Translated frame number |
| rsp_attr | output | 3 | Cache attribute of the matched half |
| rsp_dirty | output | 1 | Dirty bit of the matched half |
| rd_hi | output | 32 | Read data: page pair and identifier |
| rd_mask | output | 32 | Read data: page mask |
| rd_lo0 | output | 32 | Read data: even half |
| rd_lo1 | output | 32 | Read data: odd half |
| cnt_rd_hit | output | 16 | Load hits |
| cnt_rd_miss | output | 16 | Load misses |
| cnt_wr_hit | output | 16 | Store hits |
| cnt_wr_miss | output | 16 | Store misses |
| cnt_hits | output | 16 | Total hits |
| cnt_misses | output | 16 | Total misses |
| cnt_access | output | 16 | Total translates |

## Verification
The checks assume that software writes masks made of a run of low ones, with no holes. A mask with holes would let the select bit fall inside the ignored field. The stimulus uses only the masks 0 and 3. They also assume that `cmd_op` never takes the unused codes 6 and 7; the bench issues codes 0 to 5 only. The property on the access counter assumes that fewer than 2^16 translates occur, so the counter never wraps. The bench issues a few dozen.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 12;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PAIR_W   = VPN_W - 1;
    localparam int ASID_W   = 8;
    localparam int PFN_W    = 20;
    localparam int ATTR_W   = 3;
    localparam int MASK_W   = 16;
    localparam int WORD_W   = 32;
    localparam int RB_SHIFT = 11;
    localparam int PFN_LSB  = 6;

    localparam logic [VA_W-1:0] UNCACHED_BITS = 32'hA000_0000;

    typedef enum logic [2:0] {
        OP_LOOKUP  = 3'd0,
        OP_PROBE   = 3'd1,
        OP_WRITE   = 3'd2,
        OP_FLUSH   = 3'd3,
        OP_READ    = 3'd4,
        OP_READPTR = 3'd5
    } tlbx_op_e;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [ATTR_W-1:0] attr;
        logic              dirty;
        logic              valid;
    } tlbx_half_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [PAIR_W-1:0] pair;
        logic [ASID_W-1:0] asid;
        logic              glob;
        tlbx_half_t        odd;
        tlbx_half_t        even;
    } tlbx_entry_t;

    // Page-number bits excluded from the compare: the select bit and all below it.
    function automatic logic [VPN_W-1:0] ignore_bits(input logic [MASK_W-1:0] m);
        logic [VPN_W-1:0] ext;
        ext = VPN_W'(m);
        return (ext << 1) | VPN_W'(1);
    endfunction

    // One-hot position of the even/odd select bit.
    function automatic logic [VPN_W-1:0] select_bit(input logic [MASK_W-1:0] m);
        return ignore_bits(m) & ~VPN_W'(m);
    endfunction

    function automatic logic [WORD_W-1:0] pack_half(input tlbx_half_t h, input logic g);
        return WORD_W'({h.pfn, h.attr, h.dirty, h.valid, g});
    endfunction

    function automatic logic [WORD_W-1:0] pack_hi(input logic [PAIR_W-1:0] p,
                                                   input logic [ASID_W-1:0] a);
        return (WORD_W'(p) << RB_SHIFT) | WORD_W'(a);
    endfunction

    function automatic logic [WORD_W-1:0] pack_mask(input logic [MASK_W-1:0] m);
        return WORD_W'(m) << RB_SHIFT;
    endfunction

endpackage

// File: rtl/tlbx_match.sv
module tlbx_match
    import tlbx_pkg::*;
(
    input  tlbx_entry_t       ent,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output logic              hit,
    output logic              odd
);
    logic [VPN_W-1:0] diff;
    logic             live;
    logic             owner_ok;

    always_comb begin
        diff     = (vpn ^ {ent.pair, 1'b0}) & ~ignore_bits(ent.mask);
        live     = ent.even.valid | ent.odd.valid;
        owner_ok = ent.glob | (ent.asid == asid);
        hit      = live && owner_ok && (diff == '0);
        odd      = |(vpn & select_bit(ent.mask));
    end
endmodule

// File: rtl/tlbx_prio.sv
module tlbx_prio #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N) + 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '1;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbx_stats.sv
module tlbx_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             is_store,
    input  logic             hit,
    output logic [CNT_W-1:0] rd_hit,
    output logic [CNT_W-1:0] rd_miss,
    output logic [CNT_W-1:0] wr_hit,
    output logic [CNT_W-1:0] wr_miss,
    output logic [CNT_W-1:0] hits,
    output logic [CNT_W-1:0] misses,
    output logic [CNT_W-1:0] accesses
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hit  <= '0;
            rd_miss <= '0;
            wr_hit  <= '0;
            wr_miss <= '0;
        end else if (en) begin
            unique case ({is_store, hit})
                2'b01:   rd_hit  <= rd_hit  + 1'b1;
                2'b00:   rd_miss <= rd_miss + 1'b1;
                2'b11:   wr_hit  <= wr_hit  + 1'b1;
                default: wr_miss <= wr_miss + 1'b1;
            endcase
        end
    end

    assign hits     = rd_hit + wr_hit;
    assign misses   = rd_miss + wr_miss;
    assign accesses = hits + misses;
endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
    import tlbx_pkg::*;
#(
    parameter int N     = 16,
    parameter int CNT_W = 16,
    localparam int SLOT_W = $clog2(N),
    localparam int IDX_W  = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [31:0]       cmd_va,
    input  logic [7:0]        cmd_asid,
    input  logic              cmd_store,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic              cmd_adv,
    input  logic [31:0]       wr_hi,
    input  logic [31:0]       wr_mask,
    input  logic [31:0]       wr_lo0,
    input  logic [31:0]       wr_lo1,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_inval,
    output logic              rsp_uncached,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [19:0]       rsp_pfn,
    output logic [2:0]        rsp_attr,
    output logic              rsp_dirty,
    output logic [31:0]       rd_hi,
    output logic [31:0]       rd_mask,
    output logic [31:0]       rd_lo0,
    output logic [31:0]       rd_lo1,
    output logic [CNT_W-1:0]  cnt_rd_hit,
    output logic [CNT_W-1:0]  cnt_rd_miss,
    output logic [CNT_W-1:0]  cnt_wr_hit,
    output logic [CNT_W-1:0]  cnt_wr_miss,
    output logic [CNT_W-1:0]  cnt_hits,
    output logic [CNT_W-1:0]  cnt_misses,
    output logic [CNT_W-1:0]  cnt_access
);
    tlbx_op_e          op;
    tlbx_entry_t       tbl [N];
    tlbx_entry_t       wr_ent;
    logic [VPN_W-1:0]  vpn;
    logic [N-1:0]      hit_vec;
    logic [N-1:0]      odd_vec;
    logic              found;
    logic [IDX_W-1:0]  match_idx;
    logic [SLOT_W-1:0] match_slot;
    tlbx_half_t        match_half;
    logic [SLOT_W-1:0] ptr;
    logic [SLOT_W-1:0] rd_slot;
    logic              rd_ok;
    logic              idx_in_range;
    logic              do_lookup;
    logic              unused_bits;

    assign op           = tlbx_op_e'(cmd_op);
    assign vpn          = cmd_va[VA_W-1:PG_SHIFT];
    assign idx_in_range = cmd_idx < IDX_W'(N);
    assign do_lookup    = cmd_valid && (op == OP_LOOKUP);
    assign unused_bits  = ^{cmd_va[PG_SHIFT-1:0], wr_hi, wr_mask, wr_lo0, wr_lo1, match_idx};

    // Unpack the write words.
    always_comb begin
        wr_ent.mask       = wr_mask[RB_SHIFT +: MASK_W];
        wr_ent.pair       = wr_hi[RB_SHIFT +: PAIR_W];
        wr_ent.asid       = wr_hi[ASID_W-1:0];
        wr_ent.glob       = wr_lo0[0] & wr_lo1[0];
        wr_ent.even.pfn   = wr_lo0[PFN_LSB +: PFN_W];
        wr_ent.even.attr  = wr_lo0[5:3];
        wr_ent.even.dirty = wr_lo0[2];
        wr_ent.even.valid = wr_lo0[1];
        wr_ent.odd.pfn    = wr_lo1[PFN_LSB +: PFN_W];
        wr_ent.odd.attr   = wr_lo1[5:3];
        wr_ent.odd.dirty  = wr_lo1[2];
        wr_ent.odd.valid  = wr_lo1[1];
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            tlbx_match u_match (
                .ent  (tbl[g]),
                .vpn  (vpn),
                .asid (cmd_asid),
                .hit  (hit_vec[g]),
                .odd  (odd_vec[g])
            );
        end
    endgenerate

    tlbx_prio #(.N(N), .IDX_W(IDX_W)) u_prio (
        .req   (hit_vec),
        .found (found),
        .idx   (match_idx)
    );

    assign match_slot = match_idx[SLOT_W-1:0];
    assign match_half = odd_vec[match_slot] ? tbl[match_slot].odd : tbl[match_slot].even;
    assign rd_slot    = (op == OP_READPTR) ? ptr : cmd_idx[SLOT_W-1:0];
    assign rd_ok      = (op == OP_READPTR) || idx_in_range;

    // Table storage.
    always_ff @(posedge clk) begin
        if (rst || (cmd_valid && op == OP_FLUSH)) begin
            for (int i = 0; i < N; i++) tbl[i] <= '0;
        end else if (cmd_valid && op == OP_WRITE && idx_in_range) begin
            tbl[cmd_idx[SLOT_W-1:0]] <= wr_ent;
        end
    end

    // Replacement pointer.
    always_ff @(posedge clk) begin
        if (rst || (cmd_valid && op == OP_FLUSH)) begin
            ptr <= '0;
        end else if (cmd_valid && op == OP_READPTR && cmd_adv) begin
            ptr <= (ptr == SLOT_W'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end

    // Response registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_inval    <= 1'b0;
            rsp_uncached <= 1'b0;
            rsp_idx      <= '1;
            rsp_pfn      <= '0;
            rsp_attr     <= '0;
            rsp_dirty    <= 1'b0;
            rd_hi        <= '0;
            rd_mask      <= '0;
            rd_lo0       <= '0;
            rd_lo1       <= '0;
        end else begin
            rsp_valid    <= cmd_valid;
            rsp_hit      <= 1'b0;
            rsp_inval    <= 1'b0;
            rsp_uncached <= 1'b0;
            rsp_idx      <= '1;
            rsp_pfn      <= '0;
            rsp_attr     <= '0;
            rsp_dirty    <= 1'b0;
            rd_hi        <= '0;
            rd_mask      <= '0;
            rd_lo0       <= '0;
            rd_lo1       <= '0;
            if (cmd_valid) begin
                case (op)
                    OP_LOOKUP: begin
                        rsp_hit      <= found;
                        rsp_idx      <= found ? match_idx : '1;
                        rsp_inval    <= found && !match_half.valid;
                        rsp_pfn      <= found ? match_half.pfn : '0;
                        rsp_attr     <= found ? match_half.attr : '0;
                        rsp_dirty    <= found && match_half.dirty;
                        rsp_uncached <= (cmd_va & UNCACHED_BITS) == UNCACHED_BITS;
                    end
                    OP_PROBE: begin
                        rsp_hit <= found;
                        rsp_idx <= found ? match_idx : '1;
                    end
                    OP_READ, OP_READPTR: begin
                        if (rd_ok) begin
                            rd_hi   <= pack_hi(tbl[rd_slot].pair, tbl[rd_slot].asid);
                            rd_mask <= pack_mask(tbl[rd_slot].mask);
                            rd_lo0  <= pack_half(tbl[rd_slot].even, tbl[rd_slot].glob);
                            rd_lo1  <= pack_half(tbl[rd_slot].odd, tbl[rd_slot].glob);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    tlbx_stats #(.CNT_W(CNT_W)) u_stats (
        .clk      (clk),
        .rst      (rst),
        .en       (do_lookup),
        .is_store (cmd_store),
        .hit      (found),
        .rd_hit   (cnt_rd_hit),
        .rd_miss  (cnt_rd_miss),
        .wr_hit   (cnt_wr_hit),
        .wr_miss  (cnt_wr_miss),
        .hits     (cnt_hits),
        .misses   (cnt_misses),
        .accesses (cnt_access)
    );
endmodule

// File: rtl/tlbx_check.sv
module tlbx_check
    import tlbx_pkg::*;
#(
    parameter int N     = 16,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(N) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [31:0]      cmd_va,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_inval,
    input logic             rsp_uncached,
    input logic [IDX_W-1:0] rsp_idx,
    input logic [CNT_W-1:0] cnt_access
);
    logic is_lookup;
    assign is_lookup = cmd_valid && (cmd_op == 3'd0);

    assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);

    assert_rsp_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid);

    assert_hit_code_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit == (rsp_idx != '1)));

    assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (rsp_idx < IDX_W'(N)));

    assert_inval_hit_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_inval |-> rsp_hit);

    assert_uncached_R11: assert property (@(posedge clk) disable iff (rst)
        (is_lookup && ((cmd_va & UNCACHED_BITS) == UNCACHED_BITS)) |=> rsp_uncached);

    assert_access_step_R12: assert property (@(posedge clk) disable iff (rst)
        is_lookup |=> (cnt_access == $past(cnt_access) + 1'b1));

    assert_access_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !is_lookup |=> $stable(cnt_access));
endmodule

bind tlbx_top tlbx_check #(.N(N), .CNT_W(CNT_W)) u_check (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_va       (cmd_va),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_inval    (rsp_inval),
    .rsp_uncached (rsp_uncached),
    .rsp_idx      (rsp_idx),
    .cnt_access   (cnt_access)
);

// File: tb/tlbx_top_test.sv
module tlbx_top_test;
    localparam int N     = 16;
    localparam int CNT_W = 16;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = '0;
    logic [31:0]      cmd_va = '0;
    logic [7:0]       cmd_asid = '0;
    logic             cmd_store = 1'b0;
    logic [IDX_W-1:0] cmd_idx = '0;
    logic             cmd_adv = 1'b0;
    logic [31:0]      wr_hi = '0, wr_mask = '0, wr_lo0 = '0, wr_lo1 = '0;
    logic             rsp_valid, rsp_hit, rsp_inval, rsp_uncached, rsp_dirty;
    logic [IDX_W-1:0] rsp_idx;
    logic [19:0]      rsp_pfn;
    logic [2:0]       rsp_attr;
    logic [31:0]      rd_hi, rd_mask, rd_lo0, rd_lo1;
    logic [CNT_W-1:0] cnt_rd_hit, cnt_rd_miss, cnt_wr_hit, cnt_wr_miss;
    logic [CNT_W-1:0] cnt_hits, cnt_misses, cnt_access;

    int total = 0, fails = 0;
    int e_rh = 0, e_rm = 0, e_wh = 0, e_wm = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tlbx_top #(.N(N), .CNT_W(CNT_W)) uut (.*);

    function automatic logic [31:0] mk_hi(input int pair, input int asid);
        return (32'(pair) << 11) | 32'(asid);
    endfunction
    function automatic logic [31:0] mk_lo(input int pfn, input int attr, input bit d,
                                          input bit v, input bit g);
        return (32'(pfn) << 6) | (32'(attr) << 3) | (32'(d) << 2) | (32'(v) << 1) | 32'(g);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input int op, input logic [31:0] va, input int asid, input bit st,
                         input int idx, input bit adv);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_va = va; cmd_asid = 8'(asid);
        cmd_store = st; cmd_idx = IDX_W'(idx); cmd_adv = adv;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic put(input int idx, input logic [31:0] hi, input logic [31:0] mw,
                       input logic [31:0] l0, input logic [31:0] l1);
        wr_hi = hi; wr_mask = mw; wr_lo0 = l0; wr_lo1 = l1;
        issue(2, 0, 0, 0, idx, 0);
    endtask

    task automatic lk(input string req, input logic [31:0] va, input int asid, input bit st,
                      input bit exp_hit, input int exp_pfn);
        issue(0, va, asid, st, 0, 0);
        check({req, " hit"}, rsp_hit, exp_hit);
        if (exp_hit) check({req, " pfn"}, rsp_pfn, exp_pfn);
        if (st) begin if (exp_hit) e_wh++; else e_wm++; end
        else begin if (exp_hit) e_rh++; else e_rm++; end
    endtask

    task automatic t_reset;
        check("R13 rsp_valid after reset", rsp_valid, 0);
        check("R13 access count after reset", cnt_access, 0);
        check("R13 hit count after reset", cnt_hits, 0);
    endtask

    task automatic t_basic;
        put(0, mk_hi('h10, 5), 0, mk_lo('h111, 3, 1, 1, 0), mk_lo('h222, 2, 0, 1, 0));
        lk("R1 even half", 32'h0002_0000, 5, 0, 1, 'h111);
        check("R1 even attr", rsp_attr, 3);
        check("R1 even dirty", rsp_dirty, 1);
        check("R13 rsp_valid on command", rsp_valid, 1);
        lk("R1 odd half", 32'h0002_1000, 5, 1, 1, 'h222);
        check("R1 odd dirty", rsp_dirty, 0);
        lk("R2 other asid misses", 32'h0002_0000, 6, 0, 0, 0);
    endtask

    task automatic t_global;
        put(1, mk_hi('h20, 9), 0, mk_lo('h333, 0, 0, 1, 1), mk_lo('h334, 0, 0, 1, 1));
        lk("R2 global ignores asid", 32'h0004_0000, 77, 0, 1, 'h333);
    endtask

    task automatic t_mask;
        put(2, mk_hi('h100, 5), 32'(3) << 11, mk_lo('h444, 1, 0, 1, 0), mk_lo('h555, 1, 0, 1, 0));
        lk("R1 masked bits ignored even", 32'h0020_3000, 5, 0, 1, 'h444);
        lk("R1 select bit 2 odd", 32'h0020_6000, 5, 1, 1, 'h555);
        lk("R1 bit above field compared", 32'h0020_8000, 5, 0, 0, 0);
    endtask

    task automatic t_valid;
        put(3, mk_hi('h300, 5), 0, mk_lo('h666, 0, 0, 0, 0), mk_lo('h667, 0, 0, 0, 0));
        lk("R3 both halves invalid", 32'h0060_0000, 5, 0, 0, 0);
        issue(1, 32'h0060_0000, 5, 0, 0, 0);
        check("R5 probe not found", rsp_idx, 5'h1F);
        put(4, mk_hi('h400, 5), 0, mk_lo('h777, 0, 0, 1, 0), mk_lo('h778, 0, 0, 0, 0));
        lk("R6 invalid odd half", 32'h0080_1000, 5, 1, 1, 'h778);
        check("R6 inval flag set", rsp_inval, 1);
        lk("R6 valid even half", 32'h0080_0000, 5, 0, 1, 'h777);
        check("R6 inval flag clear", rsp_inval, 0);
    endtask

    task automatic t_priority;
        put(6, mk_hi('h500, 0), 0, mk_lo('h600, 0, 0, 1, 1), mk_lo('h601, 0, 0, 1, 1));
        put(5, mk_hi('h500, 0), 0, mk_lo('h500, 0, 0, 1, 1), mk_lo('h501, 0, 0, 1, 1));
        issue(1, 32'h00A0_0000, 3, 0, 0, 0);
        check("R4 probe lowest slot", rsp_idx, 5);
        check("R5 probe hit flag", rsp_hit, 1);
        lk("R4 lookup lowest slot", 32'h00A0_0000, 3, 0, 1, 'h500);
        issue(1, 32'h0002_0000, 5, 0, 0, 0);
        check("R5 probe slot 0", rsp_idx, 0);
    endtask

    task automatic t_readback;
        issue(4, 0, 0, 0, 0, 0);
        check("R10 hi word", rd_hi, 32'h0000_8005);
        check("R10 even word", rd_lo0, 32'h0000_445E);
        check("R10 odd word", rd_lo1, 32'h0000_8892);
        issue(4, 0, 0, 0, 2, 0);
        check("R10 mask word", rd_mask, 32'h0000_1800);
        issue(4, 0, 0, 0, 1, 0);
        check("R10 global bit", rd_lo0[0], 1);
    endtask

    task automatic t_write;
        put(16, mk_hi('h7F0, 5), 0, mk_lo('hFFF, 0, 0, 1, 0), mk_lo('hFFE, 0, 0, 1, 0));
        issue(4, 0, 0, 0, 0, 0);
        check("R7 out of range keeps slot 0", rd_hi, 32'h0000_8005);
        check("R7 out of range keeps even", rd_lo0, 32'h0000_445E);
        lk("R7 out of range not stored", 32'h00FE_0000, 5, 0, 0, 0);
        put(0, mk_hi('h700, 5), 0, mk_lo('h999, 0, 0, 1, 0), mk_lo('h998, 0, 0, 1, 0));
        lk("R7 old mapping gone", 32'h0002_0000, 5, 0, 0, 0);
        lk("R7 new mapping", 32'h00E0_0000, 5, 1, 1, 'h999);
    endtask

    task automatic t_pointer;
        issue(5, 0, 0, 0, 0, 0);
        check("R9 pointer starts at 0", rd_hi, mk_hi('h700, 5));
        issue(5, 0, 0, 0, 0, 0);
        check("R9 no advance holds", rd_hi, mk_hi('h700, 5));
        issue(5, 0, 0, 0, 0, 1);
        issue(5, 0, 0, 0, 0, 1);
        check("R9 advance to slot 1", rd_hi, mk_hi('h20, 9));
        for (int i = 2; i < N; i++) issue(5, 0, 0, 0, 0, 1);
        check("R9 last slot empty", rd_hi, 0);
        issue(5, 0, 0, 0, 0, 0);
        check("R9 wraps to slot 0", rd_hi, mk_hi('h700, 5));
    endtask

    task automatic t_flush;
        for (int i = 0; i < 3; i++) issue(5, 0, 0, 0, 0, 1);
        issue(3, 0, 0, 0, 0, 0);
        issue(4, 0, 0, 0, 3, 0);
        check("R8 slot 3 cleared", rd_hi, 0);
        lk("R8 mapping gone", 32'h0080_0000, 5, 0, 0, 0);
        put(0, mk_hi('h123, 5), 0, mk_lo('h1, 0, 0, 1, 0), mk_lo('h2, 0, 0, 1, 0));
        issue(5, 0, 0, 0, 0, 0);
        check("R8 pointer back to 0", rd_hi, mk_hi('h123, 5));
    endtask

    task automatic t_uncached;
        lk("R11 A0000000", 32'hA000_0000, 5, 0, 0, 0);
        check("R11 uncached A0000000", rsp_uncached, 1);
        lk("R11 BFFFF000", 32'hBFFF_F000, 5, 1, 0, 0);
        check("R11 uncached BFFFF000", rsp_uncached, 1);
        lk("R11 80000000", 32'h8000_0000, 5, 0, 0, 0);
        check("R11 cached 80000000", rsp_uncached, 0);
        lk("R11 20000000", 32'h2000_0000, 5, 0, 0, 0);
        check("R11 cached 20000000", rsp_uncached, 0);
    endtask

    task automatic t_counters;
        @(negedge clk);
        check("R12 load hits", cnt_rd_hit, e_rh);
        check("R12 load misses", cnt_rd_miss, e_rm);
        check("R12 store hits", cnt_wr_hit, e_wh);
        check("R12 store misses", cnt_wr_miss, e_wm);
        check("R12 total hits", cnt_hits, e_rh + e_wh);
        check("R12 total misses", cnt_misses, e_rm + e_wm);
        check("R12 total accesses", cnt_access, e_rh + e_rm + e_wh + e_wm);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_basic();
        t_global();
        t_mask();
        t_valid();
        t_priority();
        t_readback();
        t_write();
        t_pointer();
        t_flush();
        t_uncached();
        t_counters();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule